// File: doc/BRIEF.md
# Convolutional Re-encode Bit Error Monitor

This block estimates the raw channel bit error rate in front of a rate-1/2, constraint-length-7 convolutional decoder. Every bit the decoder emits is passed through a local copy of the encoder and its puncturing stage. The expected channel bits are then compared with the received hard-decision bits, which are held back in a delay line so that they line up with the decoder's fixed latency. Each mismatch on a transmitted (unpunctured) position counts as one channel error.

Errors are summed over a measurement window of four times a 24-bit programmed value, counted in decoded bits. At the last bit of each window the sum is copied into a result register and an interrupt can be raised. The accumulator restarts on the same cycle, so no bit falls between two windows. A coarse mode runs alongside the window. It toggles a status pin every time a small error counter reaches an 8-bit limit. The pin's toggle frequency tracks the error rate, which helps when aligning a dish by ear.

The window controller is a two-state machine. `ST_OFF` holds the counters cleared while the window value is zero. The transition ENABLE (window value becomes nonzero) enters `ST_COUNT`. In `ST_COUNT` the controller counts decoded bits and errors, and latches the result at each window end. The transition DISABLE (window value returns to zero) goes back to `ST_OFF`.

Top module: `vit_ber_monitor`

## Requirements
- R1: Expected channel bits come from encoding `dec_bit` with generators 171 and 133 octal. With u the current decoded bit and s0..s5 the six previous ones (s0 newest): X = u^s0^s1^s2^s5 and Y = u^s1^s2^s4^s5. The encoder history starts at zero after reset and advances on every `dec_valid`.
- R2: `rate_sel` codes 0..5 select rates 1/2, 2/3, 3/4, 5/6, 6/7 and 7/8. The puncture phase advances once per decoded bit, and `sync_i` resets it to column 0. The columns that use X, from column 0, are: "1", "10", "101", "10101", "100101", "1000101". The columns that use Y are: "1", "11", "110", "11010", "111010", "1111010".
- R3: On each `dec_valid` the expected X/Y bits are compared with the received pair pushed DELAY `rx_valid` events earlier. Only positions that are used in the current column count, so a decoded bit adds 0, 1 or 2 errors. Mismatches on punctured positions are ignored.
- R4: With `win_cfg` nonzero, a window spans 4*`win_cfg` decoded bits. At its last bit, `err_result` takes the error total of that window (including the last bit) on the next edge. Counting restarts at once, with no bit skipped.
- R5: `err_result` changes only at a window end. Reading the status (`status_rd`) and idle cycles leave it unchanged.
- R6: At a window end with `irq_en` high, `irq_n` goes low. A `status_rd` pulse returns it high. With `irq_en` low, `irq_n` stays high.
- R7: With `win_cfg` zero the measurement is off: `err_result` and `irq_n` do not change, whatever errors arrive.
- R8: With `coarse_en` high and `coarse_max` nonzero, errors add to a coarse counter. When the counter plus the new errors reaches `coarse_max`, `coarse_status` toggles and the counter restarts from zero. With `coarse_en` low, `coarse_status` holds its value and the counter is cleared.
- R9: After reset, `err_result` is 0, `irq_n` is 1 and `coarse_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Restart the puncture phase at column 0 |
| rate_sel | input | 3 | Code-rate select, 0..5 |
| rx_valid | input | 1 | Received pair strobe |
| rx_x | input | 1 | Received hard bit, X position |
| rx_y | input | 1 | Received hard bit, Y position |
| dec_valid | input | 1 | Decoded bit strobe |
| dec_bit | input | 1 | Decoded bit |
| win_cfg | input | 24 | Window value; length is four times this, 0 = off |
| irq_en | input | 1 | Interrupt enable for window completion |
| status_rd | input | 1 | Host read of interrupt status; releases the interrupt |
| coarse_en | input | 1 | Enable the coarse toggle indication |
| coarse_max | input | 8 | Coarse error limit |
| err_result | output | 24 | Error count latched from the last complete window |
| irq_n | output | 1 | Active-low interrupt |
| coarse_status | output | 1 | Coarse toggle indication |

## Verification
The assertions assume that `rate_sel` only changes while `sync_i` re-aligns the phase, and that the error accumulator never saturates within a window. The bench keeps to this by issuing a sync after every rate change and by using short windows. The alignment check assumes that the decoder emits exactly one decoded bit per received pair, DELAY pairs behind the received stream. To meet this, the bench first pushes DELAY received pairs alone and then strobes both valids together on every step. It changes the window value only by passing through zero, so the controller always leaves through `ST_OFF`.

// File: rtl/ber_mon_pkg.sv
package ber_mon_pkg;

    typedef enum logic [2:0] {
        RATE_1_2 = 3'd0,
        RATE_2_3 = 3'd1,
        RATE_3_4 = 3'd2,
        RATE_5_6 = 3'd3,
        RATE_6_7 = 3'd4,
        RATE_7_8 = 3'd5
    } code_rate_e;

    typedef enum logic {
        ST_OFF   = 1'b0,
        ST_COUNT = 1'b1
    } win_state_e;

    localparam int PH_W = 3;

    function automatic logic [PH_W-1:0] punct_period(input logic [2:0] rate);
        case (rate)
            RATE_2_3: return 3'd2;
            RATE_3_4: return 3'd3;
            RATE_5_6: return 3'd5;
            RATE_6_7: return 3'd6;
            RATE_7_8: return 3'd7;
            default:  return 3'd1;
        endcase
    endfunction

    // returns {use_x, use_y} for one column of the puncture pattern
    function automatic logic [1:0] punct_use(input logic [2:0] rate, input logic [PH_W-1:0] col);
        logic [6:0] mx;
        logic [6:0] my;
        case (rate)
            RATE_2_3: begin mx = 7'b0000001; my = 7'b0000011; end
            RATE_3_4: begin mx = 7'b0000101; my = 7'b0000011; end
            RATE_5_6: begin mx = 7'b0010101; my = 7'b0001011; end
            RATE_6_7: begin mx = 7'b0101001; my = 7'b0010111; end
            RATE_7_8: begin mx = 7'b1010001; my = 7'b0101111; end
            default:  begin mx = 7'b0000001; my = 7'b0000001; end
        endcase
        return {mx[col], my[col]};
    endfunction

endpackage

// File: rtl/conv_reencoder.sv
module conv_reencoder
    import ber_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [2:0] rate_sel,
    input  logic       dec_valid,
    input  logic       dec_bit,
    output logic       exp_x,
    output logic       exp_y,
    output logic       use_x,
    output logic       use_y
);

    logic [5:0]      hist_q;
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] period;

    assign period = punct_period(rate_sel);

    // hist_q[0] is the most recent previous decoded bit
    assign exp_x = dec_bit ^ hist_q[0] ^ hist_q[1] ^ hist_q[2] ^ hist_q[5];
    assign exp_y = dec_bit ^ hist_q[1] ^ hist_q[2] ^ hist_q[4] ^ hist_q[5];
    assign {use_x, use_y} = punct_use(rate_sel, phase_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (dec_valid) begin
            hist_q <= {hist_q[4:0], dec_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (sync_i) begin
            phase_q <= '0;
        end else if (dec_valid) begin
            phase_q <= (phase_q >= period - 3'd1) ? '0 : phase_q + 3'd1;
        end
    end

    p_sync_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (phase_q == '0));

    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !sync_i) |=> (phase_q < $past(period)));

    p_hist_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> (hist_q[0] == $past(dec_bit)));

endmodule

// File: rtl/rx_delay_line.sv
module rx_delay_line #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_x,
    input  logic in_y,
    output logic tap_x,
    output logic tap_y
);

    logic [1:0] stage_q [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (in_valid) begin
                    if (g == 0) begin
                        stage_q[g] <= {in_x, in_y};
                    end else begin
                        stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
                    end
                end
            end
        end
    endgenerate

    assign {tap_x, tap_y} = stage_q[DEPTH-1];

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(stage_q[DEPTH-1]));

endmodule

// File: rtl/err_window_ctrl.sv
module err_window_ctrl
    import ber_mon_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int ERR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] win_cfg,
    input  logic             dec_valid,
    input  logic [1:0]       errs,
    input  logic             irq_en,
    input  logic             status_rd,
    output logic [ERR_W-1:0] err_result,
    output logic             irq_n
);

    localparam int LEN_W = CNT_W + 2;

    win_state_e       state_q;
    win_state_e       state_d;
    logic [LEN_W-1:0] win_len;
    logic [LEN_W-1:0] bit_cnt_q;
    logic [ERR_W-1:0] err_acc_q;
    logic [ERR_W-1:0] acc_next;
    logic [ERR_W:0]   acc_sum;
    logic             win_on;
    logic             last_bit;
    logic             win_end;
    logic             irq_flag_q;

    assign win_len  = {win_cfg, 2'b00};
    assign win_on   = (win_cfg != '0);
    assign last_bit = (bit_cnt_q >= win_len - 1'b1);
    assign win_end  = (state_q == ST_COUNT) && win_on && dec_valid && last_bit;
    assign acc_sum  = {1'b0, err_acc_q} + {{(ERR_W-1){1'b0}}, errs};
    assign acc_next = acc_sum[ERR_W] ? '1 : acc_sum[ERR_W-1:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (win_on)  state_d = ST_COUNT;
            ST_COUNT: if (!win_on) state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            err_acc_q <= '0;
        end else if (state_q != ST_COUNT || !win_on) begin
            bit_cnt_q <= '0;
            err_acc_q <= '0;
        end else if (dec_valid) begin
            if (last_bit) begin
                bit_cnt_q <= '0;
                err_acc_q <= '0;
            end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                err_acc_q <= acc_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_result <= '0;
        else if (win_end) err_result <= acc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 irq_flag_q <= 1'b0;
        else if (win_end && irq_en) irq_flag_q <= 1'b1;
        else if (status_rd)         irq_flag_q <= 1'b0;
    end

    assign irq_n = ~irq_flag_q;

    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> $stable(err_result));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(irq_en));

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> ($stable(err_result) && !$fell(irq_n)));

    p_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ({{(LEN_W-ERR_W+1){1'b0}}, err_acc_q} <= {bit_cnt_q, 1'b0}));

endmodule

// File: rtl/coarse_toggle.sv
module coarse_toggle #(
    parameter int MAX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             coarse_en,
    input  logic [MAX_W-1:0] coarse_max,
    input  logic             dec_valid,
    input  logic [1:0]       errs,
    output logic             coarse_status
);

    logic [MAX_W-1:0] cnt_q;
    logic [MAX_W:0]   cnt_sum;
    logic             active;

    assign active  = coarse_en && (coarse_max != '0);
    assign cnt_sum = {1'b0, cnt_q} + {{(MAX_W-1){1'b0}}, errs};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q         <= '0;
            coarse_status <= 1'b0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (dec_valid) begin
            if (cnt_sum >= {1'b0, coarse_max}) begin
                cnt_q         <= '0;
                coarse_status <= ~coarse_status;
            end else begin
                cnt_q <= cnt_sum[MAX_W-1:0];
            end
        end
    end

    p_coarse_below_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && dec_valid) |=> (cnt_q < $past(coarse_max)));

    p_coarse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !coarse_en |=> $stable(coarse_status));

endmodule

// File: rtl/vit_ber_monitor.sv
module vit_ber_monitor
    import ber_mon_pkg::*;
#(
    parameter int DELAY = 4,
    parameter int WIN_W = 24,
    parameter int ERR_W = 24,
    parameter int MAX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [2:0]       rate_sel,
    input  logic             rx_valid,
    input  logic             rx_x,
    input  logic             rx_y,
    input  logic             dec_valid,
    input  logic             dec_bit,
    input  logic [WIN_W-1:0] win_cfg,
    input  logic             irq_en,
    input  logic             status_rd,
    input  logic             coarse_en,
    input  logic [MAX_W-1:0] coarse_max,
    output logic [ERR_W-1:0] err_result,
    output logic             irq_n,
    output logic             coarse_status
);

    logic exp_x, exp_y, use_x, use_y;
    logic tap_x, tap_y;
    logic miss_x, miss_y;
    logic [1:0] errs;

    conv_reencoder u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (sync_i),
        .rate_sel (rate_sel),
        .dec_valid(dec_valid),
        .dec_bit  (dec_bit),
        .exp_x    (exp_x),
        .exp_y    (exp_y),
        .use_x    (use_x),
        .use_y    (use_y)
    );

    rx_delay_line #(.DEPTH(DELAY)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(rx_valid),
        .in_x    (rx_x),
        .in_y    (rx_y),
        .tap_x   (tap_x),
        .tap_y   (tap_y)
    );

    assign miss_x = dec_valid && use_x && (tap_x ^ exp_x);
    assign miss_y = dec_valid && use_y && (tap_y ^ exp_y);
    assign errs   = {1'b0, miss_x} + {1'b0, miss_y};

    err_window_ctrl #(.CNT_W(WIN_W), .ERR_W(ERR_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_cfg   (win_cfg),
        .dec_valid (dec_valid),
        .errs      (errs),
        .irq_en    (irq_en),
        .status_rd (status_rd),
        .err_result(err_result),
        .irq_n     (irq_n)
    );

    coarse_toggle #(.MAX_W(MAX_W)) u_coarse (
        .clk          (clk),
        .rst_n        (rst_n),
        .coarse_en    (coarse_en),
        .coarse_max   (coarse_max),
        .dec_valid    (dec_valid),
        .errs         (errs),
        .coarse_status(coarse_status)
    );

    p_errs_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (errs == 2'd0));

endmodule

// File: tb/test_vit_ber_monitor.sv
module test_vit_ber_monitor;

    localparam int DLY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic [2:0]  rate_sel = 3'd0;
    logic        rx_valid = 1'b0, rx_x = 1'b0, rx_y = 1'b0;
    logic        dec_valid = 1'b0, dec_bit = 1'b0;
    logic [23:0] win_cfg = '0;
    logic        irq_en = 1'b0, status_rd = 1'b0, coarse_en = 1'b0;
    logic [7:0]  coarse_max = '0;
    logic [23:0] err_result;
    logic        irq_n, coarse_status;

    always #2.5 clk = ~clk;

    vit_ber_monitor #(.DELAY(DLY)) i_vit_ber_monitor (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .rate_sel(rate_sel),
        .rx_valid(rx_valid), .rx_x(rx_x), .rx_y(rx_y),
        .dec_valid(dec_valid), .dec_bit(dec_bit), .win_cfg(win_cfg),
        .irq_en(irq_en), .status_rd(status_rd), .coarse_en(coarse_en),
        .coarse_max(coarse_max), .err_result(err_result), .irq_n(irq_n),
        .coarse_status(coarse_status)
    );

    int n_chk = 0, n_bad = 0;
    string pat_x [6] = '{"1", "10", "101", "10101", "100101", "1000101"};
    string pat_y [6] = '{"1", "11", "110", "11010", "111010", "1111010"};

    bit       data_a [64];
    bit       fx_a   [64];
    bit       fy_a   [64];
    bit [5:0] h = '0;
    int tx_i = 0, ph = 0, rate_m = 0;
    int win_m = 0, cnt_m = 0, acc_m = 0, res_m = 0;
    bit flag_m = 0, st_m = 0;
    int ccnt_m = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        check(err_result == res_m, "R4 R5 result", err_result, res_m);
        check(irq_n == !flag_m, "R6 irq_n", irq_n, !flag_m);
        check(coarse_status == st_m, "R8 status", coarse_status, st_m);
    endtask

    // new transmitted item: encode in tx order and drive the received pair
    task automatic push_tx(input bit px, input bit py);
        bit u;
        bit [6:0] w;
        u = bit'($urandom % 2);
        w = {u, h};
        h = {u, h[5:1]};
        data_a[tx_i % 64] = u;
        fx_a[tx_i % 64] = px;
        fy_a[tx_i % 64] = py;
        rx_x = (^(w & 7'o171)) ^ px;
        rx_y = (^(w & 7'o133)) ^ py;
        rx_valid = 1'b1;
        tx_i++;
    endtask

    task automatic step(input bit px, input bit py);
        int d, e;
        bit ux, uy;
        d = tx_i - DLY;
        push_tx(px, py);
        dec_bit = data_a[d % 64];
        dec_valid = 1'b1;
        ux = (pat_x[rate_m][ph] == "1");
        uy = (pat_y[rate_m][ph] == "1");
        e = int'(ux & fx_a[d % 64]) + int'(uy & fy_a[d % 64]);
        ph = (ph + 1) % pat_x[rate_m].len();
        @(posedge clk); #1;
        rx_valid = 1'b0; dec_valid = 1'b0;
        if (win_m != 0) begin
            if (cnt_m == 4 * win_m - 1) begin
                res_m = acc_m + e; acc_m = 0; cnt_m = 0;
                if (irq_en) flag_m = 1;
            end else begin
                acc_m += e; cnt_m++;
            end
        end
        if (coarse_en && coarse_max != 0) begin
            if (ccnt_m + e >= int'(coarse_max)) begin st_m = !st_m; ccnt_m = 0; end
            else ccnt_m += e;
        end else ccnt_m = 0;
        check_outputs();
    endtask

    task automatic run(input int n, input int prob);
        for (int i = 0; i < n; i++)
            step(($urandom % prob) == 0, ($urandom % prob) == 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            check_outputs();
        end
    endtask

    task automatic set_rate(input int r);
        rate_sel = 3'(r); rate_m = r;
        sync_i = 1'b1;
        @(posedge clk); #1;
        sync_i = 1'b0; ph = 0;
    endtask

    task automatic set_win(input int w);
        win_cfg = '0;
        @(posedge clk); #1;
        win_cfg = 24'(w); win_m = w; cnt_m = 0; acc_m = 0;
        @(posedge clk); #1;
    endtask

    task automatic read_status();
        status_rd = 1'b1;
        @(posedge clk); #1;
        status_rd = 1'b0; flag_m = 0;
        check_outputs();
    endtask

    task automatic t_reset_r9();
        check(err_result == 0, "R9 reset result", err_result, 0);
        check(irq_n == 1, "R9 reset irq_n", irq_n, 1);
        check(coarse_status == 0, "R9 reset status", coarse_status, 0);
    endtask

    task automatic t_rates_r1_r2_r3();
        irq_en = 1'b1;
        for (int r = 0; r < 6; r++) begin
            set_rate(r);
            set_win(8);
            run(96, 5);
            check(err_result == res_m, "R1 R2 R3 rate sweep result", err_result, res_m);
            read_status();
        end
    endtask

    task automatic t_window_r4();
        set_rate(2);
        set_win(1);
        irq_en = 1'b1;
        run(3, 3);
        check(irq_n == 1, "R4 no end before fourth bit", irq_n, 1);
        run(1, 3);
        check(irq_n == 0, "R4 window end after four bits", irq_n, 0);
        read_status();
        run(4, 2);
        check(err_result == res_m && irq_n == 0, "R4 back-to-back window", err_result, res_m);
        read_status();
    endtask

    task automatic t_noclear_r5();
        int held;
        set_win(2);
        run(8, 2);
        held = err_result;
        read_status();
        read_status();
        idle(6);
        check(err_result == held, "R5 result not cleared by reads", err_result, held);
    endtask

    task automatic t_irq_r6();
        set_win(2);
        irq_en = 1'b0;
        run(16, 2);
        check(irq_n == 1, "R6 no irq when disabled", irq_n, 1);
        irq_en = 1'b1;
        run(8, 2);
        check(irq_n == 0, "R6 irq asserted", irq_n, 0);
        read_status();
        check(irq_n == 1, "R6 irq released by status read", irq_n, 1);
    endtask

    task automatic t_off_r7();
        int held;
        set_win(0);
        held = err_result;
        run(40, 1);
        check(err_result == held && irq_n == 1, "R7 off ignores errors", err_result, held);
    endtask

    task automatic t_coarse_r8();
        bit first;
        int toggles = 0;
        set_rate(0);
        coarse_max = 8'd3;
        coarse_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            first = coarse_status;
            step(($urandom % 2) == 0, ($urandom % 2) == 0);
            if (coarse_status != first) toggles++;
        end
        check(toggles > 5, "R8 status toggles", toggles, 6);
        coarse_en = 1'b0;
        first = coarse_status;
        run(30, 1);
        check(coarse_status == first, "R8 disabled status held", coarse_status, first);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset_r9();
        for (int i = 0; i < DLY; i++) begin
            push_tx(1'b0, 1'b0);
            @(posedge clk); #1;
            rx_valid = 1'b0;
        end
        t_rates_r1_r2_r3();
        t_window_r4();
        t_noclear_r5();
        t_irq_r6();
        t_off_r7();
        t_coarse_r8();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule